// File: doc/BRIEF.md
# Serial Message Port with Interrupt Framing

This block is the device-side end of a four-wire serial control link over which a host trades byte messages with a decoder core. The host lowers chip select, clocks in an address/direction byte, and then either sends command bytes or collects response bytes. Command words are 24 bits and travel as three bytes, most significant first. Incoming bytes go into a receive FIFO that the core drains. Response bytes that the core queues go into a transmit FIFO that the host drains.

All serial inputs are sampled with the system clock through two-stage synchronisers. Bits are taken on rising serial-clock edges and driven on falling edges (clock idles low, MSB first). The active-low interrupt line tells the host when response bytes are waiting, and it also frames the length of a read. It rises during the final pending byte. When the core starts a new message while a read is under way, the line gives a single one-period high pulse.

Top module: `spi_msg_port`

## Requirements
- R1: After reset, `irq_n` and the chip-select view are idle: `irq_n`=1, `sdo_en`=0, `cmd_avail`=0, `rsp_full`=0.
- R2: The first byte after chip select falls is an address/direction byte, sampled MSB first on rising serial-clock edges. Bits 7:1 must be zero. Bit 0 is 0 for a write and 1 for a read.
- R3: In a write, each following byte enters the receive FIFO in arrival order, its first bit being bit 7. `cmd_avail` is high while that FIFO holds a byte and `cmd_data` shows the oldest byte.
- R4: In a read, `sdo_en` is high from the end of the address byte until chip select rises. Data is presented MSB first and changes only after falling serial-clock edges. `sdo_en` stays low in a write.
- R5: Outside a pulse, `irq_n` is low exactly when the transmit FIFO holds at least one byte.
- R6: A response byte leaves the transmit FIFO at the first rising edge of the byte that carries it. During a read, `irq_n` is therefore high from the second bit of the last pending byte.
- R7: If the core queues a byte flagged as a message start while a read is in progress, `irq_n` is high for exactly one serial-clock period, measured from one falling edge to the next.
- R8: A read byte taken while the transmit FIFO is empty is 0x00, and nothing is consumed.
- R9: If the address field is nonzero, the whole transaction is ignored. No byte is stored, no response byte is consumed, and `sdo_en` stays low.
- R10: The transmit FIFO holds DEPTH (16) bytes. `rsp_full` is high when it is full, and a push while full is dropped.
- R11: Raising chip select mid-byte discards the partial byte and restarts decoding at the address byte. A response byte whose first bit was never clocked is not consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select from host |
| sck | input | 1 | Serial clock from host, idles low |
| sdi | input | 1 | Serial data from host |
| sdo | output | 1 | Serial data to host |
| sdo_en | output | 1 | Output enable for the shared data line |
| irq_n | output | 1 | Active-low response-pending / read framing |
| cmd_avail | output | 1 | Receive FIFO not empty |
| cmd_data | output | 8 | Oldest received byte |
| cmd_pop | input | 1 | Core removes the oldest received byte |
| rsp_push | input | 1 | Core queues a response byte |
| rsp_sop | input | 1 | Queued byte starts a new message |
| rsp_data | input | 8 | Response byte to queue |
| rsp_full | output | 1 | Transmit FIFO full |

## Verification
On every cycle, the assertions check the following:
- the transmit count never exceeds its depth;
- bytes leave the transmit FIFO only when it is non-empty and only on the first bit of a read byte;
- a framing pulse begins only on a falling serial-clock edge;
- a rejected address never drives the line or stores a byte;
- chip select high always returns the decoder to its idle state.

The bench scenarios cover the rest: byte order and values through both FIFOs, the exact bit at which `irq_n` marks the last byte, the one-period pulse when a message is queued during a read, and recovery after an aborted transfer.

// File: rtl/spi_msg_port.sv
module spi_msg_port #(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sck,
  input  logic       sdi,
  output logic       sdo,
  output logic       sdo_en,
  output logic       irq_n,
  output logic       cmd_avail,
  output logic [7:0] cmd_data,
  input  logic       cmd_pop,
  input  logic       rsp_push,
  input  logic       rsp_sop,
  input  logic [7:0] rsp_data,
  output logic       rsp_full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [2:0] cs_p, sck_p;
  logic [1:0] sdi_p;
  logic [2:0] bitcnt;
  logic [6:0] rx_sr;
  logic [7:0] tx_sr;
  logic       in_data, rd_q, ok_q, sdo_q, sdo_en_q, pop_pend, arm_q, pulse_q;

  logic [7:0]    o_mem [DEPTH];
  logic [7:0]    i_mem [DEPTH];
  logic [AW-1:0] o_wp, o_rp, i_wp, i_rp;
  logic [CW-1:0] o_cnt, i_cnt;

  wire       active   = ~cs_p[1];
  wire       sck_rise = sck_p[1] & ~sck_p[2];
  wire       sck_fall = ~sck_p[1] & sck_p[2];
  wire [7:0] byte_in  = {rx_sr, sdi_p[1]};
  wire       byte_end = active & sck_rise & (bitcnt == 3'd7);
  wire       addr_end = byte_end & ~in_data;
  wire       data_end = byte_end & in_data;
  wire       load     = (addr_end & (byte_in == 8'h01)) | (data_end & rd_q & ok_q);
  wire       o_empty  = (o_cnt == '0);
  wire       o_pop    = active & sck_rise & (bitcnt == 3'd0) & pop_pend;
  wire       o_push   = rsp_push & (o_cnt != CW'(DEPTH));
  wire       i_push   = data_end & ~rd_q & ok_q & (i_cnt != CW'(DEPTH));
  wire       i_pop    = cmd_pop & (i_cnt != '0);
  wire       arm_set  = o_push & rsp_sop & active & in_data & rd_q & ok_q;

  assign sdo       = sdo_q;
  assign sdo_en    = sdo_en_q;
  assign irq_n     = o_empty | pulse_q;
  assign rsp_full  = (o_cnt == CW'(DEPTH));
  assign cmd_avail = (i_cnt != '0);
  assign cmd_data  = i_mem[i_rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_p  <= 3'b111;
      sck_p <= '0;
      sdi_p <= '0;
    end else begin
      cs_p  <= {cs_p[1:0], cs_n};
      sck_p <= {sck_p[1:0], sck};
      sdi_p <= {sdi_p[0], sdi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitcnt   <= '0;
      rx_sr    <= '0;
      tx_sr    <= '0;
      in_data  <= 1'b0;
      rd_q     <= 1'b0;
      ok_q     <= 1'b0;
      sdo_q    <= 1'b0;
      sdo_en_q <= 1'b0;
      pop_pend <= 1'b0;
    end else if (!active) begin
      bitcnt   <= '0;
      in_data  <= 1'b0;
      rd_q     <= 1'b0;
      ok_q     <= 1'b0;
      sdo_q    <= 1'b0;
      sdo_en_q <= 1'b0;
      pop_pend <= 1'b0;
    end else if (sck_rise) begin
      bitcnt <= bitcnt + 3'd1;
      rx_sr  <= {rx_sr[5:0], sdi_p[1]};
      if (o_pop) pop_pend <= 1'b0;
      if (addr_end) begin
        in_data <= 1'b1;
        rd_q    <= byte_in[0];
        ok_q    <= (byte_in[7:1] == 7'd0);
        if (byte_in == 8'h01) sdo_en_q <= 1'b1;
      end
      if (load) begin
        tx_sr    <= o_empty ? 8'h00 : o_mem[o_rp];
        pop_pend <= ~o_empty;
      end
    end else if (sck_fall && sdo_en_q) begin
      sdo_q <= tx_sr[7];
      tx_sr <= {tx_sr[6:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else if (!active) begin
      arm_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      if (sck_fall) begin
        if (pulse_q) pulse_q <= 1'b0;
        else if (arm_q) begin
          pulse_q <= 1'b1;
          arm_q   <= 1'b0;
        end
      end
      if (arm_set) arm_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (o_push) o_mem[o_wp] <= rsp_data;
    if (i_push) i_mem[i_wp] <= byte_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_wp <= '0; o_rp <= '0; o_cnt <= '0;
      i_wp <= '0; i_rp <= '0; i_cnt <= '0;
    end else begin
      if (o_push) o_wp <= nxt(o_wp);
      if (o_pop)  o_rp <= nxt(o_rp);
      o_cnt <= o_cnt + CW'(o_push) - CW'(o_pop);
      if (i_push) i_wp <= nxt(i_wp);
      if (i_pop)  i_rp <= nxt(i_rp);
      i_cnt <= i_cnt + CW'(i_push) - CW'(i_pop);
    end
  end

  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    o_cnt <= CW'(DEPTH));
  a_r8_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    o_pop |-> o_cnt != '0);
  a_r6_pop_first_bit: assert property (@(posedge clk) disable iff (!rst_n)
    o_pop |-> (bitcnt == 3'd0) && in_data && rd_q && sdo_en_q);
  a_r7_pulse_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_q) |-> $past(sck_fall));
  a_r9_bad_addr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (in_data && !ok_q) |-> !sdo_en_q && !i_push && !o_pop);
  a_r11_cs_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (bitcnt == 3'd0) && !in_data && !sdo_en_q && !pulse_q);
endmodule

// File: tb/spi_msg_port_bench.sv
module spi_msg_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;
  localparam int DEPTH = 16;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic cmd_pop = 1'b0, rsp_push = 1'b0, rsp_sop = 1'b0;
  logic [7:0] rsp_data = 8'h00;
  logic sdo, sdo_en, irq_n, cmd_avail, rsp_full;
  logic [7:0] cmd_data;

  spi_msg_port #(.DEPTH(DEPTH)) u_spi_msg_port (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi), .sdo(sdo),
    .sdo_en(sdo_en), .irq_n(irq_n), .cmd_avail(cmd_avail), .cmd_data(cmd_data),
    .cmd_pop(cmd_pop), .rsp_push(rsp_push), .rsp_sop(rsp_sop),
    .rsp_data(rsp_data), .rsp_full(rsp_full));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, hi_cnt = 0;
  bit settled = 1'b0, done = 1'b0;
  logic en_and = 1'b1, en_or = 1'b0, irq_b1 = 1'b0;
  logic [7:0] rsp_q[$];
  logic [7:0] cmd_q[$];
  logic [7:0] rx;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (settled) begin
    chk(irq_n == (rsp_q.size() == 0), "R5 irq_n at rest", irq_n, rsp_q.size() == 0);
    chk(cmd_avail == (cmd_q.size() != 0), "R3 cmd_avail", cmd_avail, cmd_q.size() != 0);
    chk(rsp_full == (rsp_q.size() == DEPTH), "R10 rsp_full", rsp_full, rsp_q.size() == DEPTH);
  end

  task automatic idle(input int n);
    settled = 1'b0;
    repeat (6) @(negedge clk);
    settled = 1'b1;
    repeat (n) @(negedge clk);
    settled = 1'b0;
  endtask

  task automatic push(input logic [7:0] d, input bit sop);
    @(negedge clk);
    rsp_data = d; rsp_sop = sop; rsp_push = 1'b1;
    @(negedge clk);
    rsp_push = 1'b0; rsp_sop = 1'b0;
    if (rsp_q.size() < DEPTH) rsp_q.push_back(d);
  endtask

  task automatic pop_check(input string tag);
    logic [7:0] e;
    e = cmd_q.pop_front();
    @(negedge clk);
    chk(cmd_data == e, tag, cmd_data, e);
    cmd_pop = 1'b1;
    @(negedge clk);
    cmd_pop = 1'b0;
  endtask

  task automatic cs_lo();
    @(negedge clk); cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic cs_hi();
    @(negedge clk); cs_n = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      sdi = tx[i];
      repeat (HALF) @(negedge clk);
      r[i] = sdo;
      en_and &= sdo_en;
      en_or  |= sdo_en;
      hi_cnt += int'(irq_n);
      if (i == 6) irq_b1 = irq_n;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic read_bytes(input int n, input string tag, input bit chk_irq);
    logic [7:0] e;
    logic [7:0] r;
    for (int k = 0; k < n; k++) begin
      spi_byte(8'h00, r);
      e = (rsp_q.size() != 0) ? rsp_q.pop_front() : 8'h00;
      chk(r == e, tag, r, e);
      if (chk_irq) chk(irq_b1 == (rsp_q.size() == 0), "R6 irq_n framing", irq_b1, rsp_q.size() == 0);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    chk(irq_n === 1'b1, "R1 irq_n reset", irq_n, 1);
    chk(sdo_en === 1'b0, "R1 sdo_en reset", sdo_en, 0);
    chk(cmd_avail === 1'b0, "R1 cmd_avail reset", cmd_avail, 0);
    chk(rsp_full === 1'b0, "R1 rsp_full reset", rsp_full, 0);
    rst_n = 1'b1;
    idle(10);

    // R2 R3: write of one 24-bit command, MSB byte first
    en_or = 1'b0;
    cs_lo();
    spi_byte(8'h00, rx);
    spi_byte(8'hA5, rx); spi_byte(8'h3C, rx); spi_byte(8'h81, rx);
    cs_hi();
    cmd_q.push_back(8'hA5); cmd_q.push_back(8'h3C); cmd_q.push_back(8'h81);
    chk(en_or == 1'b0, "R4 sdo_en low in write", en_or, 0);
    idle(10);
    pop_check("R3 cmd byte 0"); pop_check("R3 cmd byte 1"); pop_check("R3 cmd byte 2");
    idle(10);

    // R5 R6 R4: six-byte response read
    push(8'h9A, 1'b1);
    for (int k = 1; k < 6; k++) push(8'(8'h40 + k * 7), 1'b0);
    idle(10);
    cs_lo();
    en_or = 1'b0;
    spi_byte(8'h01, rx);
    chk(en_or == 1'b0, "R4 sdo_en low during address", en_or, 0);
    en_and = 1'b1;
    read_bytes(6, "R4 read data", 1'b1);
    chk(en_and == 1'b1, "R4 sdo_en high during read", en_and, 1);
    cs_hi();
    idle(10);

    // R8: empty read
    cs_lo();
    spi_byte(8'h01, rx);
    hi_cnt = 0;
    read_bytes(2, "R8 empty read null", 1'b1);
    chk(hi_cnt == 16, "R8 irq_n stays high", hi_cnt, 16);
    cs_hi();
    idle(10);

    // R9: nonzero address in write and read
    push(8'h77, 1'b1); push(8'h12, 1'b0);
    cs_lo(); spi_byte(8'h04, rx); spi_byte(8'h11, rx); cs_hi();
    idle(10);
    chk(cmd_avail == 1'b0, "R9 bad write dropped", cmd_avail, 0);
    en_or = 1'b0;
    cs_lo(); spi_byte(8'h03, rx); spi_byte(8'h00, rx); cs_hi();
    chk(en_or == 1'b0, "R9 bad read not driven", en_or, 0);
    idle(10);
    cs_lo(); spi_byte(8'h01, rx); read_bytes(2, "R9 nothing consumed", 1'b1); cs_hi();
    idle(10);

    // R10: overflow
    for (int k = 0; k < DEPTH + 1; k++) push(8'(8'h10 + k), k == 0);
    idle(10);
    chk(rsp_full == 1'b1, "R10 full flag", rsp_full, 1);
    cs_lo(); spi_byte(8'h01, rx);
    read_bytes(DEPTH + 1, "R10 extra push dropped", 1'b1);
    cs_hi();
    idle(10);

    // R7: new message queued mid-read
    for (int k = 0; k < 6; k++) push(8'(8'hC0 + k), k == 0);
    cs_lo(); spi_byte(8'h01, rx);
    read_bytes(2, "R7 read before queue", 1'b1);
    repeat (HALF) @(negedge clk);
    for (int k = 0; k < 6; k++) push(8'(8'hD0 + k), k == 0);
    hi_cnt = 0;
    read_bytes(9, "R7 read across messages", 1'b0);
    chk(hi_cnt == 1, "R7 one-period pulse", hi_cnt, 1);
    read_bytes(1, "R7 final byte", 1'b1);
    cs_hi();
    idle(10);

    // R11: aborts
    cs_lo();
    for (int i = 0; i < 3; i++) begin
      sdi = 1'b1;
      repeat (HALF) @(negedge clk); sck = 1'b1;
      repeat (HALF) @(negedge clk); sck = 1'b0;
    end
    cs_hi();
    cs_lo(); spi_byte(8'h00, rx); spi_byte(8'h42, rx); cs_hi();
    cmd_q.push_back(8'h42);
    idle(10);
    pop_check("R11 recovery after partial address");
    push(8'h5E, 1'b1);
    cs_lo(); spi_byte(8'h01, rx); cs_hi();
    idle(10);
    cs_lo(); spi_byte(8'h01, rx); read_bytes(1, "R11 unclocked byte kept", 1'b1); cs_hi();
    idle(10);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule